// File: doc/BRIEF.md
# Nine-Bit Symbol Error Patcher

This block repairs a 512-byte data chunk held in a byte-wide buffer after a Reed-Solomon decoder has located its symbol errors. The chunk is treated as a string of 9-bit symbols packed across byte boundaries. The decoder hands over up to four error reports, each a 9-bit symbol index with a 9-bit error mask, together with a count of valid reports and a flag that marks the chunk as beyond repair.

For each valid report the block turns the symbol index into a byte position and a bit offset. It reads the two bytes that the symbol straddles through a single-port buffer memory, XORs the mask into the 9-bit field, and writes both bytes back. Each repair takes a fixed number of cycles. A one-cycle done pulse closes the chunk, with a fail flag when the chunk was marked uncorrectable. The decoder itself and the syndrome logic sit outside this block.

Top module: `sym9_patch`

## Requirements
- R1: After reset `done`, `fail` and `mem_en` are low, and the memory port stays idle until a `start` pulse is accepted.
- R2: For index `idx`, let `p = idx*9`, `i = p>>3`, `j = p&7`. If `j` is 0, then `i` becomes `i-1` and `j` becomes 7; otherwise `j` becomes `j-1`. The 16-bit window is byte `i` (upper half) over byte `i-1` (lower half). It is XORed with the mask shifted left by `j`, and both bytes are written back.
- R3: When `i` equals 512 (index 456), only byte 511 is read and written. It receives the low byte of the shifted mask.
- R4: Index 0, and any index whose `i` exceeds 512 (index 457 and above), is skipped with no memory access, and the chunk stays unchanged for that report.
- R5: Report slot k occupies bits `[9k+8:9k]` of `rep_idx` and `rep_mask`. Only slots below `err_cnt` are used, and they are applied from slot `err_cnt-1` down to slot 0.
- R6: If `uncor` is high at `start`, no memory access is made and `done` pulses with `fail` high.
- R7: If `err_cnt` is 0 or greater than 4, no memory access is made and `done` pulses with `fail` low.
- R8: `done` is a one-cycle pulse. It is high in the cycle after clock edge `E0+6a+2s`, where `E0` is the edge that samples `start`, `a` is the number of reports applied and `s` the number skipped. `fail` is never high without `done`.
- R9: The buffer has a one-cycle read latency. Within one repair, the lower byte `i-1` is written first and byte `i` is written in the next cycle. `mem_we` is only high together with `mem_en`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin patching a chunk; sampled only when idle |
| err_cnt | input | 3 | Number of valid report slots |
| uncor | input | 1 | Chunk is uncorrectable |
| rep_idx | input | 36 | Four packed 9-bit symbol indices |
| rep_mask | input | 36 | Four packed 9-bit error masks |
| mem_en | output | 1 | Buffer access enable |
| mem_we | output | 1 | Buffer write enable |
| mem_addr | output | 9 | Buffer byte address |
| mem_wdata | output | 8 | Buffer write data |
| mem_rdata | input | 8 | Buffer read data, valid one cycle after a read |
| done | output | 1 | Chunk finished, one-cycle pulse |
| fail | output | 1 | Chunk uncorrectable, valid with done |

## Verification
The two bytes of an applied report are written 4 and 5 cycles after that report's turn begins. A skipped report makes no write and costs 2 cycles. `done` follows the start edge by exactly 6 cycles per applied report plus 2 per skipped one, and by none for an aborted chunk. The driver computes each report's write pair from a golden image in descending slot order and queues it. It also queues the expected done cycle. The monitor samples on the falling edge and pops one queue item for every write and every done pulse, so a write or pulse that comes early, late or unexpected is caught there. After each chunk the whole buffer is compared with the golden image.

// File: rtl/sym9_pkg.sv
package sym9_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        S_IDLE = 3'd0,
        S_RDLO = 3'd1,
        S_RDHI = 3'd2,
        S_CAP  = 3'd3,
        S_WRLO = 3'd4,
        S_WRHI = 3'd5,
        S_NEXT = 3'd6,
        S_FIN  = 3'd7
    } seq_state_e;

endpackage

// File: rtl/sym9_locate.sv
// Turns a symbol index into the byte pair and bit offset it covers.
module sym9_locate #(
    parameter int IDX_W       = 9,
    parameter int SYM_W       = 9,
    parameter int CHUNK_BYTES = 512,
    parameter int ADDR_W      = 9
) (
    input  logic [IDX_W-1:0]  idx,
    output logic [ADDR_W-1:0] lo_addr,
    output logic [ADDR_W-1:0] hi_addr,
    output logic [2:0]        shift,
    output logic              skip,
    output logic              trunc
);
    localparam int PROD_W = IDX_W + $clog2(SYM_W) + 1;
    localparam int POS_W  = PROD_W - 3;
    localparam logic [POS_W-1:0] END_POS = POS_W'(CHUNK_BYTES);

    logic [PROD_W-1:0] prod;
    logic [POS_W-1:0]  pos;

    always_comb begin
        prod = PROD_W'(idx) * PROD_W'(SYM_W);
        if (prod[2:0] == 3'd0) begin
            pos   = prod[PROD_W-1:3] - POS_W'(1);
            shift = 3'd7;
        end else begin
            pos   = prod[PROD_W-1:3];
            shift = prod[2:0] - 3'd1;
        end
        skip    = (idx == '0) || (pos > END_POS);
        trunc   = (pos == END_POS);
        lo_addr = ADDR_W'(pos - POS_W'(1));
        hi_addr = pos[ADDR_W-1:0];
    end
endmodule

// File: rtl/sym9_merge.sv
// XORs a shifted error mask into a two-byte window.
module sym9_merge
    import sym9_pkg::*;
#(
    parameter int SYM_W = 9
) (
    input  logic [SYM_W-1:0]  mask,
    input  logic [2:0]        shift,
    input  logic [BYTE_W-1:0] lo_in,
    input  logic [BYTE_W-1:0] hi_in,
    output logic [BYTE_W-1:0] lo_out,
    output logic [BYTE_W-1:0] hi_out
);
    localparam int WIN_W = 2 * BYTE_W;

    logic [WIN_W-1:0] pat;

    always_comb begin
        pat    = WIN_W'(mask) << shift;
        lo_out = lo_in ^ pat[BYTE_W-1:0];
        hi_out = hi_in ^ pat[WIN_W-1:BYTE_W];
    end
endmodule

// File: rtl/sym9_patch.sv
module sym9_patch
    import sym9_pkg::*;
#(
    parameter int CHUNK_BYTES = 512,
    parameter int SLOTS       = 4,
    parameter int SYM_W       = 9,
    parameter int IDX_W       = 9,
    parameter int CNT_W       = 3,
    parameter int ADDR_W      = $clog2(CHUNK_BYTES)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic [CNT_W-1:0]        err_cnt,
    input  logic                    uncor,
    input  logic [SLOTS*IDX_W-1:0]  rep_idx,
    input  logic [SLOTS*SYM_W-1:0]  rep_mask,
    output logic                    mem_en,
    output logic                    mem_we,
    output logic [ADDR_W-1:0]       mem_addr,
    output logic [BYTE_W-1:0]       mem_wdata,
    input  logic [BYTE_W-1:0]       mem_rdata,
    output logic                    done,
    output logic                    fail
);
    localparam int SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;
    localparam logic [CNT_W-1:0] MAX_CNT = CNT_W'(SLOTS);

    typedef struct packed {
        seq_state_e                   state;
        logic [SLOT_W-1:0]            slot;
        logic                         fail;
        logic [BYTE_W-1:0]            lo;
        logic [BYTE_W-1:0]            hi;
        logic [SLOTS-1:0][IDX_W-1:0]  idx;
        logic [SLOTS-1:0][SYM_W-1:0]  mask;
    } seq_t;

    seq_t st_d, st_q;

    logic [ADDR_W-1:0] lo_addr, hi_addr;
    logic [2:0]        shift;
    logic              skip, trunc, cnt_ok;
    logic [BYTE_W-1:0] new_lo, new_hi;

    sym9_locate #(
        .IDX_W(IDX_W), .SYM_W(SYM_W),
        .CHUNK_BYTES(CHUNK_BYTES), .ADDR_W(ADDR_W)
    ) u_locate (
        .idx     (st_q.idx[st_q.slot]),
        .lo_addr (lo_addr),
        .hi_addr (hi_addr),
        .shift   (shift),
        .skip    (skip),
        .trunc   (trunc)
    );

    sym9_merge #(.SYM_W(SYM_W)) u_merge (
        .mask   (st_q.mask[st_q.slot]),
        .shift  (shift),
        .lo_in  (st_q.lo),
        .hi_in  (st_q.hi),
        .lo_out (new_lo),
        .hi_out (new_hi)
    );

    assign cnt_ok = (err_cnt != '0) && (err_cnt <= MAX_CNT);

    always_comb begin
        st_d      = st_q;
        mem_en    = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = lo_addr;
        mem_wdata = '0;
        done      = 1'b0;
        fail      = 1'b0;
        case (st_q.state)
            S_IDLE: begin
                if (start) begin
                    st_d.idx  = rep_idx;
                    st_d.mask = rep_mask;
                    st_d.fail = uncor;
                    if (uncor || !cnt_ok) begin
                        st_d.state = S_FIN;
                    end else begin
                        st_d.slot  = SLOT_W'(err_cnt - CNT_W'(1));
                        st_d.state = S_RDLO;
                    end
                end
            end
            S_RDLO: begin
                if (skip) begin
                    st_d.state = S_NEXT;
                end else begin
                    mem_en     = 1'b1;
                    mem_addr   = lo_addr;
                    st_d.state = S_RDHI;
                end
            end
            S_RDHI: begin
                mem_en     = !trunc;
                mem_addr   = hi_addr;
                st_d.lo    = mem_rdata;
                st_d.state = S_CAP;
            end
            S_CAP: begin
                st_d.hi    = trunc ? '0 : mem_rdata;
                st_d.state = S_WRLO;
            end
            S_WRLO: begin
                mem_en     = 1'b1;
                mem_we     = 1'b1;
                mem_addr   = lo_addr;
                mem_wdata  = new_lo;
                st_d.state = S_WRHI;
            end
            S_WRHI: begin
                mem_en     = !trunc;
                mem_we     = !trunc;
                mem_addr   = hi_addr;
                mem_wdata  = new_hi;
                st_d.state = S_NEXT;
            end
            S_NEXT: begin
                if (st_q.slot == '0) begin
                    st_d.state = S_FIN;
                end else begin
                    st_d.slot  = st_q.slot - SLOT_W'(1);
                    st_d.state = S_RDLO;
                end
            end
            S_FIN: begin
                done       = 1'b1;
                fail       = st_q.fail;
                st_d.state = S_IDLE;
            end
            default: st_d.state = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/sym9_patch_chk.sv
module sym9_patch_chk
    import sym9_pkg::*;
#(
    parameter int SLOTS  = 4,
    parameter int CNT_W  = 3,
    parameter int ADDR_W = 9
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [CNT_W-1:0]  err_cnt,
    input logic              uncor,
    input logic              mem_en,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              done,
    input logic              fail,
    input seq_state_e        state
);
    localparam logic [CNT_W-1:0]  MAX_CNT  = CNT_W'(SLOTS);
    localparam logic [ADDR_W-1:0] TOP_ADDR = '1;

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE) |-> !mem_en);

    // R6
    uncor_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE && start && uncor) |=> (done && fail && !mem_en));

    // R7
    bad_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE && start && !uncor && (err_cnt == '0 || err_cnt > MAX_CNT))
        |=> (done && !fail && !mem_en));

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8
    fail_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fail |-> done);

    // R9
    we_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> mem_en);

    // R9
    pair_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_WRLO && mem_we && mem_addr != TOP_ADDR)
        |=> (mem_we && mem_addr == $past(mem_addr) + ADDR_W'(1)));
endmodule

bind sym9_patch sym9_patch_chk #(
    .SLOTS(SLOTS), .CNT_W(CNT_W), .ADDR_W(ADDR_W)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .err_cnt  (err_cnt),
    .uncor    (uncor),
    .mem_en   (mem_en),
    .mem_we   (mem_we),
    .mem_addr (mem_addr),
    .done     (done),
    .fail     (fail),
    .state    (st_q.state)
);

// File: tb/sym9_patch_tb_top.sv
`timescale 1ns/1ps
module sym9_patch_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  err_cnt = '0;
    logic        uncor = 1'b0;
    logic [35:0] rep_idx = '0;
    logic [35:0] rep_mask = '0;
    logic        mem_en, mem_we, done, fail;
    logic [8:0]  mem_addr;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata = '0;

    logic [7:0] bmem [512];
    int         gold [512];
    int         cyc = 0;
    int         checks = 0;
    int         fails = 0;

    typedef struct { int addr; int data; string tag; } wr_t;
    typedef struct { int at; bit fl; string tag; } dn_t;
    wr_t wq[$];
    dn_t dq[$];

    always #2.5 clk = ~clk;

    sym9_patch dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .err_cnt(err_cnt),
        .uncor(uncor), .rep_idx(rep_idx), .rep_mask(rep_mask),
        .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .done(done), .fail(fail)
    );

    // buffer model: one-cycle read latency
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (mem_en) begin
            if (mem_we) bmem[mem_addr] <= mem_wdata;
            else        mem_rdata <= bmem[mem_addr];
        end
    end

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // monitor: pops one expected item per write and per done pulse
    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_en && mem_we) begin
                if (wq.size() == 0) begin
                    chk(1'b0, "R4", "unexpected write addr", int'(mem_addr), -1);
                end else begin
                    wr_t w;
                    w = wq.pop_front();
                    chk(int'(mem_addr) == w.addr, w.tag, "write addr", int'(mem_addr), w.addr);
                    chk(int'(mem_wdata) == w.data, w.tag, "write data", int'(mem_wdata), w.data);
                end
            end
            if (done) begin
                if (dq.size() == 0) begin
                    chk(1'b0, "R8", "unexpected done at cycle", cyc, -1);
                end else begin
                    dn_t d;
                    d = dq.pop_front();
                    chk(cyc == d.at, "R8", "done cycle", cyc, d.at);
                    chk(fail == d.fl, d.tag, "fail flag", int'(fail), int'(d.fl));
                end
            end
        end
    end

    task automatic run_chunk(input int cnt, input bit unc,
                             input int i0, input int i1, input int i2, input int i3,
                             input int m0, input int m1, input int m2, input int m3,
                             input string tag);
        int ix[4];
        int mk[4];
        int lat;
        dn_t d;
        ix[0] = i0; ix[1] = i1; ix[2] = i2; ix[3] = i3;
        mk[0] = m0; mk[1] = m1; mk[2] = m2; mk[3] = m3;
        lat = 0;
        if (!unc && cnt >= 1 && cnt <= 4) begin
            for (int k = cnt - 1; k >= 0; k--) begin
                int p, bi, bj, pat;
                wr_t w;
                p  = ix[k] * 9;
                bi = p >> 3;
                bj = p & 7;
                if (bj == 0) begin bi = bi - 1; bj = 7; end
                else bj = bj - 1;
                if (ix[k] == 0 || bi > 512) begin
                    lat += 2;
                end else begin
                    pat = (mk[k] & 511) << bj;
                    gold[bi-1] = gold[bi-1] ^ (pat & 255);
                    w.addr = bi - 1; w.data = gold[bi-1]; w.tag = tag;
                    wq.push_back(w);
                    if (bi < 512) begin
                        gold[bi] = gold[bi] ^ ((pat >> 8) & 255);
                        w.addr = bi; w.data = gold[bi]; w.tag = "R9";
                        wq.push_back(w);
                    end
                    lat += 6;
                end
            end
        end
        @(negedge clk);
        d.at = cyc + 1 + lat; d.fl = unc; d.tag = unc ? "R6" : tag;
        dq.push_back(d);
        err_cnt = 3'(cnt);
        uncor = unc;
        for (int k = 0; k < 4; k++) begin
            rep_idx[k*9 +: 9]  = 9'(ix[k]);
            rep_mask[k*9 +: 9] = 9'(mk[k]);
        end
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        uncor = 1'b0;
        while (dq.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
        chk(wq.size() == 0, tag, "missing writes", wq.size(), 0);
        begin
            int bad;
            bad = -1;
            for (int a = 0; a < 512; a++)
                if (bad < 0 && int'(bmem[a]) != gold[a]) bad = a;
            chk(bad < 0, tag, "buffer image first mismatch addr", bad, -1);
        end
    endtask

    task automatic summary;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL R8 watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        for (int a = 0; a < 512; a++) begin
            bmem[a] = 8'((a * 37 + 5) & 255);
            gold[a] = (a * 37 + 5) & 255;
        end
        repeat (3) @(negedge clk);
        chk(!done && !fail && !mem_en, "R1", "outputs in reset",
            int'({done, fail, mem_en}), 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk(!done && !fail && !mem_en, "R1", "outputs after reset",
            int'({done, fail, mem_en}), 0);

        // R2: plain straddling symbol, then the j==0 adjustment
        run_chunk(1, 0, 5, 0, 0, 0, 'h1FF, 0, 0, 0, "R2");
        run_chunk(1, 0, 8, 0, 0, 0, 'h0A5, 0, 0, 0, "R2");
        run_chunk(1, 0, 455, 0, 0, 0, 'h133, 0, 0, 0, "R2");
        // R3: truncated final symbol touches byte 511 only
        run_chunk(1, 0, 456, 0, 0, 0, 'h155, 0, 0, 0, "R3");
        // R4: skipped indices, alone and mixed with a valid one
        run_chunk(2, 0, 0, 457, 0, 0, 'h1FF, 'h1FF, 0, 0, "R4");
        run_chunk(3, 0, 100, 511, 0, 0, 'h011, 'h1FF, 'h1FF, 0, "R4");
        // R5: four overlapping slots, descending order
        run_chunk(4, 0, 10, 11, 10, 300, 'h0F0, 'h10F, 'h003, 'h1C7, "R5");
        // R5: slots above the count are ignored
        run_chunk(2, 0, 40, 41, 200, 201, 'h07E, 'h181, 'h1FF, 'h1FF, "R5");
        // R6: uncorrectable chunk
        run_chunk(3, 1, 20, 21, 22, 0, 'h1FF, 'h1FF, 'h1FF, 0, "R6");
        // R7: bad counts
        run_chunk(0, 0, 30, 31, 32, 33, 'h1FF, 'h1FF, 'h1FF, 'h1FF, "R7");
        run_chunk(5, 0, 30, 31, 32, 33, 'h1FF, 'h1FF, 'h1FF, 'h1FF, "R7");
        run_chunk(7, 0, 30, 31, 32, 33, 'h1FF, 'h1FF, 'h1FF, 'h1FF, "R7");
        // R8: back-to-back chunk after aborts
        run_chunk(4, 0, 1, 64, 456, 2, 'h001, 'h100, 'h0FF, 'h1AA, "R8");
        summary();
    end
endmodule